// File: doc/BRIEF.md
# Load-to-Branch Hazard Stall Unit

This block finds read-after-load hazards in a five-stage in-order pipeline with the stages fetch, decode, execute, memory and writeback. In this pipeline, conditional branches compare their two register operands in the decode stage. The block compares the source registers of the instruction in decode with the destination register of a load in execute and of a load in memory. When a hazard exists it raises a stall. The stall holds the program counter and the fetch/decode register, and it replaces the entry into execute with a no-op whose controls are all deasserted.

The block also contains the register file. A writeback write is visible to a read of the same register in the same cycle. A value that reaches writeback therefore satisfies a decode-stage reader at once. No path carries a loaded value from the memory stage back to decode, so a branch must wait until the load it depends on reaches writeback. A dependent branch placed right after a load costs two bubbles. A dependent arithmetic consumer costs one bubble, because forwarding into execute covers it after that. The block also signals when a branch in decode is taken, which it judges by operand equality.

Top module: `ldbr_hazard_unit`

## Requirements
- R1: When a branch in decode reads, as rs or rt, the nonzero destination of a load in execute, `stall` is 1 in that cycle.
- R2: When a branch in decode reads the nonzero destination of a load in memory, `stall` is 1 in that cycle. A dependent branch placed directly after a load therefore waits two cycles, and one that follows the load at a distance of two waits one cycle.
- R3: A non-branch instruction in decode stalls for one cycle only, while the load it reads is in execute. A load in memory causes it no stall.
- R4: Register 0 never causes a stall, whether a load targets it or an instruction reads it.
- R5: While `stall` is 1, `pc_en` and `ifid_en` are 0 and `idex_flush` is 1. Otherwise `pc_en` and `ifid_en` are 1 and `idex_flush` is 0.
- R6: Reset clears every register to 0. A writeback write with `wb_we`=1 stores `wb_data` into register `wb_rd` at the clock edge. Register 0 always reads 0.
- R7: In a cycle where writeback writes register k, a decode read of register k returns `wb_data` in that same cycle.
- R8: `branch_taken` is 1 only when a branch is in decode, no stall is raised, and the rs and rt read values are equal.
- R9: A non-load instruction in execute or memory never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_branch | input | 1 | Decode holds a conditional branch |
| id_use_rs | input | 1 | Decode reads rs |
| id_use_rt | input | 1 | Decode reads rt |
| id_rs | input | AW | Decode rs index |
| id_rt | input | AW | Decode rt index |
| ex_load | input | 1 | Execute holds a load |
| ex_rd | input | AW | Execute destination |
| mem_load | input | 1 | Memory stage holds a load |
| mem_rd | input | AW | Memory-stage destination |
| wb_we | input | 1 | Writeback write enable |
| wb_rd | input | AW | Writeback destination |
| wb_data | input | XLEN | Writeback value |
| rs_data | output | XLEN | Value read for rs |
| rt_data | output | XLEN | Value read for rt |
| stall | output | 1 | Hazard detected |
| pc_en | output | 1 | Program counter may advance |
| ifid_en | output | 1 | Fetch/decode register may load |
| idex_flush | output | 1 | Load a no-op into execute |
| branch_taken | output | 1 | Branch in decode resolves taken |

## Verification
The bench drives a small pipeline model with short programs of loads, arithmetic operations, branches and no-ops, and it counts the bubbles that each program receives. Directed programs place a dependent branch at distance one and at distance two from a load, a dependent arithmetic consumer at both distances, and loads to register 0. These separate the two-cycle branch wait from the one-cycle arithmetic wait, and they separate execute-stage hits from memory-stage hits. Random four-instruction programs that use only a few registers mix the dependences. A position-based model computes the expected bubble count for each of them. Separate tests of the register file check the same-cycle write-then-read path, the fact that register 0 ignores writes, and the final contents after random writes. Branch outcome is checked with equal operands, with unequal operands, and while a stall is raised.

// File: rtl/ldbr_hazard_unit.sv
module ldbr_hazard_unit #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    id_branch,
  input  logic                    id_use_rs,
  input  logic                    id_use_rt,
  input  logic [$clog2(NREG)-1:0] id_rs,
  input  logic [$clog2(NREG)-1:0] id_rt,
  input  logic                    ex_load,
  input  logic [$clog2(NREG)-1:0] ex_rd,
  input  logic                    mem_load,
  input  logic [$clog2(NREG)-1:0] mem_rd,
  input  logic                    wb_we,
  input  logic [$clog2(NREG)-1:0] wb_rd,
  input  logic [XLEN-1:0]         wb_data,
  output logic [XLEN-1:0]         rs_data,
  output logic [XLEN-1:0]         rt_data,
  output logic                    stall,
  output logic                    pc_en,
  output logic                    ifid_en,
  output logic                    idex_flush,
  output logic                    branch_taken
);
  localparam int AW = $clog2(NREG);
  localparam logic [AW-1:0] R0 = '0;

  logic [XLEN-1:0] rf [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wb_we && wb_rd != R0) begin
      rf[wb_rd] <= wb_data;
    end
  end

  assign rs_data = (id_rs == R0) ? '0 : (wb_we && wb_rd == id_rs) ? wb_data : rf[id_rs];
  assign rt_data = (id_rt == R0) ? '0 : (wb_we && wb_rd == id_rt) ? wb_data : rf[id_rt];

  logic ex_hit, mem_hit;
  assign ex_hit  = ex_load && ex_rd != R0 &&
                   ((id_use_rs && id_rs == ex_rd) || (id_use_rt && id_rt == ex_rd));
  assign mem_hit = mem_load && mem_rd != R0 &&
                   ((id_use_rs && id_rs == mem_rd) || (id_use_rt && id_rt == mem_rd));

  assign stall        = ex_hit || (id_branch && mem_hit);
  assign pc_en        = !stall;
  assign ifid_en      = !stall;
  assign idex_flush   = stall;
  assign branch_taken = id_branch && !stall && (rs_data == rt_data);

  a_r2_branch_mem_load: assert property (@(posedge clk) disable iff (!rst_n)
    (id_branch && mem_load && mem_rd != R0 && id_use_rs && id_rs == mem_rd) |-> stall);
  a_r3_alu_mem_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_branch && !ex_load) |-> !stall);
  a_r4_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == R0 && mem_rd == R0) |-> !stall);
  a_r5_hold_flush: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_en && !ifid_en && idex_flush));
  a_r9_nonload: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_load && !mem_load) |-> !stall);
  a_r6_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wb_we) && $past(wb_rd) != R0 && id_rs == $past(wb_rd)
     && !(wb_we && wb_rd == id_rs)) |-> rs_data == $past(wb_data));
  a_r6_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rt == R0) |-> rt_data == '0);
  a_r7_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && wb_rd != R0 && id_rs == wb_rd) |-> rs_data == wb_data);
  a_r8_taken: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |-> (id_branch && !stall && rs_data == rt_data));
endmodule

// File: tb/ldbr_hazard_unit_tb.sv
module ldbr_hazard_unit_tb;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int AW = $clog2(NREG);
  localparam logic [1:0] K_NOP = 2'd0, K_ALU = 2'd1, K_LD = 2'd2, K_BR = 2'd3;

  typedef struct packed { logic [1:0] k; logic [4:0] rd; logic [4:0] rs; logic [4:0] rt; } ins_t;

  logic clk = 0, rst_n = 0;
  logic id_branch = 0, id_use_rs = 0, id_use_rt = 0, ex_load = 0, mem_load = 0, wb_we = 0;
  logic [AW-1:0] id_rs = '0, id_rt = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic [XLEN-1:0] wb_data = '0, rs_data, rt_data;
  logic stall, pc_en, ifid_en, idex_flush, branch_taken;

  int checks = 0, errors = 0;
  ins_t prog [8];
  logic [XLEN-1:0] model [NREG];

  always #2.5 clk = ~clk;

  ldbr_hazard_unit #(.XLEN(XLEN), .NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .id_branch(id_branch), .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
    .id_rs(id_rs), .id_rt(id_rt), .ex_load(ex_load), .ex_rd(ex_rd), .mem_load(mem_load),
    .mem_rd(mem_rd), .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data), .rs_data(rs_data),
    .rt_data(rt_data), .stall(stall), .pc_en(pc_en), .ifid_en(ifid_en), .idex_flush(idex_flush),
    .branch_taken(branch_taken));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic ins_t mk(logic [1:0] k, int rd, int rs, int rt);
    ins_t x;
    x.k = k; x.rd = 5'(rd); x.rs = 5'(rs); x.rt = 5'(rt);
    return x;
  endfunction

  function automatic bit reads(ins_t c, logic [4:0] r);
    return (c.k != K_NOP && c.rs == r) || ((c.k == K_ALU || c.k == K_BR) && c.rt == r);
  endfunction

  function automatic int exp_bubbles(int n);
    int pos [8];
    for (int i = 0; i < n; i++) begin
      pos[i] = (i == 0) ? 0 : pos[i-1] + 1;
      for (int j = 0; j < i; j++)
        if (prog[j].k == K_LD && prog[j].rd != 0 && reads(prog[i], prog[j].rd)) begin
          int need = (prog[i].k == K_BR) ? 3 : 2;
          if (pos[j] + need > pos[i]) pos[i] = pos[j] + need;
        end
    end
    return pos[n-1] - (n - 1);
  endfunction

  task automatic drive(ins_t d, ins_t e, ins_t m);
    id_branch = (d.k == K_BR); id_use_rs = (d.k != K_NOP);
    id_use_rt = (d.k == K_ALU || d.k == K_BR);
    id_rs = d.rs; id_rt = d.rt;
    ex_load = (e.k == K_LD); ex_rd = e.rd;
    mem_load = (m.k == K_LD); mem_rd = m.rd;
  endtask

  task automatic run_prog(int n, string req);
    ins_t d, e, m;
    int pc = 1, bub = 0, guard = 0;
    d = prog[0]; e = '0; m = '0;
    while (!(pc >= n && d == ins_t'(0)) && guard < 40) begin
      guard++;
      @(negedge clk);
      drive(d, e, m);
      #1;
      check("R5", {pc_en, ifid_en, idex_flush}, {!stall, !stall, stall});
      m = e;
      if (stall) begin
        bub++; e = '0;
      end else begin
        e = d;
        d = (pc < n) ? prog[pc] : ins_t'(0);
        pc++;
      end
    end
    check(req, 64'(bub), 64'(exp_bubbles(n)));
    drive('0, '0, '0);
  endtask

  task automatic wb_write(int r, logic [XLEN-1:0] v);
    @(negedge clk);
    wb_we = 1; wb_rd = AW'(r); wb_data = v;
    if (r != 0) model[r] = v;
    @(negedge clk);
    wb_we = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    id_rs = 5; id_rt = 31; #1;
    check("R6 reset", {rs_data, rt_data}, 64'd0);
    check("R5 reset idle", {stall, pc_en, ifid_en, idex_flush}, 64'b0110);

    prog[0] = mk(K_LD, 2, 1, 0); prog[1] = mk(K_BR, 0, 2, 4);
    run_prog(2, "R1 load-branch d1");
    prog[0] = mk(K_LD, 2, 1, 0); prog[1] = mk(K_BR, 0, 4, 2);
    run_prog(2, "R1 load-branch rt d1");
    prog[0] = mk(K_LD, 2, 1, 0); prog[1] = mk(K_ALU, 5, 6, 7); prog[2] = mk(K_BR, 0, 3, 2);
    run_prog(3, "R2 load-branch d2");
    prog[0] = mk(K_LD, 3, 1, 0); prog[1] = mk(K_ALU, 4, 3, 1);
    run_prog(2, "R3 load-alu d1");
    prog[0] = mk(K_LD, 3, 1, 0); prog[1] = mk(K_NOP, 0, 0, 0); prog[2] = mk(K_ALU, 4, 1, 3);
    run_prog(3, "R3 load-alu d2");
    prog[0] = mk(K_LD, 0, 1, 0); prog[1] = mk(K_BR, 0, 0, 0);
    run_prog(2, "R4 load r0");
    prog[0] = mk(K_ALU, 2, 1, 1); prog[1] = mk(K_BR, 0, 2, 2);
    run_prog(2, "R9 alu-branch");

    for (int t = 0; t < 150; t++) begin
      for (int i = 0; i < 4; i++)
        prog[i] = mk(2'($urandom_range(3)), $urandom_range(3), $urandom_range(3), $urandom_range(3));
      for (int i = 0; i < 4; i++) if (prog[i].k == K_BR || prog[i].k == K_NOP) prog[i].rd = 0;
      if (prog[0].k == K_NOP) prog[0].k = K_LD;
      run_prog(4, "R1 R2 R3 random");
    end

    wb_write(1, 32'd5); wb_write(2, 32'd5); wb_write(3, 32'd6);
    @(negedge clk);
    id_branch = 1; id_use_rs = 1; id_use_rt = 1; id_rs = 1; id_rt = 2; #1;
    check("R8 equal", 64'(branch_taken), 64'd1);
    id_rt = 3; #1;
    check("R8 unequal", 64'(branch_taken), 64'd0);
    id_rt = 2; ex_load = 1; ex_rd = 1; #1;
    check("R8 stalled", {stall, branch_taken}, 64'b10);
    drive('0, '0, '0);

    @(negedge clk);
    wb_we = 1; wb_rd = 7; wb_data = 32'hCAFE_0007; id_rs = 7; id_rt = 7; #1;
    check("R7 bypass", {rs_data, rt_data}, {32'hCAFE_0007, 32'hCAFE_0007});
    model[7] = 32'hCAFE_0007;
    @(negedge clk); wb_we = 0;

    wb_write(0, 32'hFFFF_FFFF);
    id_rs = 0; #1;
    check("R6 r0 ignores write", 64'(rs_data), 64'd0);

    for (int i = 0; i < 100; i++) wb_write($urandom_range(NREG - 1), $urandom);
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk);
      id_rt = AW'(r); #1;
      check("R6 final value", 64'(rt_data), 64'(model[r]));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule